// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave Model

This block is a synthesizable behavioural model of a 1-Kbit serial EEPROM that answers a three-wire host: a select line, a serial clock and a serial data input, plus one serial data output. A fast system clock oversamples the three host lines through synchronizers, and the block acts on the edges it finds after synchronization. The output pin is modelled as a data bit and an output-enable bit, so an enclosing pad or a bus model can turn it into a tri-state wire.

An organization input chooses between 64 words of 16 bits and 128 bytes of 8 bits. Each instruction begins with a start bit. A two-bit operation code follows, then the address, then write data where the operation needs it. The block offers random and streaming reads. It also offers single-word write and erase, whole-array write and erase, and commands that set and clear a write-enable latch. Every change to the array runs a self-timed programming interval, counted in system clocks. The host polls ready/busy on the data output during that interval.

Top module: `mw_eeprom`

## Requirements
- R1: With the select line high, serial clock rises that see the data input low are ignored. The first rise that sees both select and data input high is the start bit.
- R2: The two bits after the start bit form the operation code: 10 read, 01 write, 11 erase, 00 extended. For an extended code, the two most significant address bits pick the command: 11 write enable, 00 write disable, 10 erase all, 01 write all. The other address bits are ignored.
- R3: With the organization input high, an address has 6 bits and a data word 16 bits. With it low, an address has 7 bits and data 8 bits. Byte address b maps to word b>>1, the upper half when b is odd.
- R4: After reset the write-enable latch is clear, and write, erase, erase-all and write-all start no programming interval. The latch keeps its value until a write-disable command. Reads work in either state.
- R5: A read drives a 0 on the rise that clocks in the last address bit. Each later rise presents the next data bit, MSB first. While select stays high, the next words follow with no further 0.
- R6: Erase sets all bits of one word to 1 and erase-all sets the whole array to 1. Write-all stores its data in every word, and in byte mode every byte.
- R7: A programming interval starts when select falls after every bit the instruction needs has been clocked in. An instruction cut short by select falling has no effect.
- R8: The output enable is low whenever the synchronized select is low. Select low returns the serial decoder to waiting for a start bit, which also stops a read.
- R9: With select high after a programming interval has started, the output is enabled and reads 0 while busy and 1 once ready. This status stays until a start bit is clocked and select then falls.
- R10: A single-word write or erase stays busy for PROG_CYC system clocks, and erase-all or write-all for BULK_CYC system clocks.
- R11: While busy, start bits are not recognized, so no instruction issued during the interval takes effect.
- R12: A streaming read wraps from the last address of the current organization back to address 0.
- R13: After reset every array bit reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the host lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Host select line, active high |
| sck_i | input | 1 | Host serial clock; bits are taken on its rising edge |
| sdi_i | input | 1 | Host serial data into the block |
| org_i | input | 1 | Organization: 1 for 16-bit words, 0 for bytes |
| sdo_o | output | 1 | Serial data or ready/busy status toward the host |
| sdo_oe_o | output | 1 | High when sdo_o should drive the wire |

## Verification
Reads run after reset, after single writes and after bulk operations, and as streams that cross word boundaries and the top address. These show dummy-bit placement, auto-increment and wrap-around. Writes are issued with the latch clear, set, and cleared again, and also cut short and issued while busy. Comparing their read-back separates a blocked instruction from one that was executed. Status is polled inside and after both interval lengths, and again after the clearing sequence, so a short interval is told apart from a long one. Byte-mode accesses are then read back in word mode to pin down the byte-to-word mapping.

// File: rtl/mw_eeprom_pkg.sv
package mw_eeprom_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_HDR,
      ST_DATA,
      ST_READ,
      ST_DONE
   } mw_state_e;

   typedef enum logic [2:0] {
      PG_NONE,
      PG_WORD,
      PG_CLEAR,
      PG_FILL,
      PG_WIPE
   } mw_prog_e;

   localparam logic [1:0] OPC_READ  = 2'b10;
   localparam logic [1:0] OPC_WRITE = 2'b01;
   localparam logic [1:0] OPC_ERASE = 2'b11;
   localparam logic [1:0] OPC_EXT   = 2'b00;

   localparam logic [1:0] EXT_WEN   = 2'b11;
   localparam logic [1:0] EXT_WDIS  = 2'b00;
   localparam logic [1:0] EXT_WIPE  = 2'b10;
   localparam logic [1:0] EXT_FILL  = 2'b01;

endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
   parameter int N      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] d_i,
   output logic [N-1:0] q_o
);
   logic [N-1:0] pipe [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[0] <= '0;
      else        pipe[0] <= d_i;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pipe[s] <= '0;
         else        pipe[s] <= pipe[s-1];
      end
   end

   assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/mw_prog_timer.sv
module mw_prog_timer #(
   parameter int SHORT_CYC = 100,
   parameter int LONG_CYC  = 300
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic long_i,
   output logic busy_o
);
   localparam int CW = $clog2(LONG_CYC + 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt_q <= '0;
      else if (start_i)         cnt_q <= long_i ? CW'(LONG_CYC) : CW'(SHORT_CYC);
      else if (cnt_q != '0)     cnt_q <= cnt_q - CW'(1);
   end

   assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/mw_array.sv
module mw_array #(
   parameter int WORD_W = 16,
   parameter int DEPTH  = 64
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en_i,
   input  logic                     wr_all_i,
   input  logic [$clog2(DEPTH)-1:0] wr_idx_i,
   input  logic [WORD_W-1:0]        wr_data_i,
   input  logic [WORD_W-1:0]        wr_mask_i,
   input  logic [$clog2(DEPTH)-1:0] rd_idx_i,
   output logic [WORD_W-1:0]        rd_data_o
);
   localparam int AW = $clog2(DEPTH);

   logic [WORD_W-1:0] words [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_word
      logic [WORD_W-1:0] cell_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cell_q <= '1;
         else if (wr_en_i && (wr_all_i || wr_idx_i == AW'(i)))
            cell_q <= (cell_q & ~wr_mask_i) | (wr_data_i & wr_mask_i);
      end
      assign words[i] = cell_q;
   end

   assign rd_data_o = words[rd_idx_i];
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
   import mw_eeprom_pkg::*;
#(
   parameter int ARRAY_BITS  = 1024,
   parameter int WORD_W      = 16,
   parameter int PROG_CYC    = 12000,
   parameter int BULK_CYC    = 30000,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_i,
   input  logic sck_i,
   input  logic sdi_i,
   input  logic org_i,
   output logic sdo_o,
   output logic sdo_oe_o
);
   localparam int DEPTH = ARRAY_BITS / WORD_W;
   localparam int AW    = $clog2(DEPTH);
   localparam int NAW   = AW + 1;
   localparam int NW    = WORD_W / 2;
   localparam int HW    = 2 + NAW;
   localparam int CNT_W = $clog2(WORD_W + HW + 1);

   if (SYNC_STAGES < 2)               begin : g_bad_sync  $error("SYNC_STAGES below 2"); end
   if (WORD_W < 4 || WORD_W % 2 != 0) begin : g_bad_word  $error("WORD_W must be even and at least 4"); end
   if (ARRAY_BITS % WORD_W != 0)      begin : g_bad_size  $error("ARRAY_BITS not a multiple of WORD_W"); end
   if ((1 << AW) != DEPTH || AW < 2)  begin : g_bad_depth $error("word count must be a power of two, at least 4"); end
   if (PROG_CYC < 1 || BULK_CYC < PROG_CYC) begin : g_bad_time $error("interval lengths out of order"); end

   // host line conditioning
   logic [2:0] sync_q;
   logic       cs_s, sck_s, sdi_s, cs_q, sck_q;
   logic       sck_rise, cs_fall;

   mw_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i({cs_i, sck_i, sdi_i}), .q_o(sync_q));
   assign {cs_s, sck_s, sdi_s} = sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q  <= 1'b0;
         sck_q <= 1'b0;
      end else begin
         cs_q  <= cs_s;
         sck_q <= sck_s;
      end
   end
   assign sck_rise = sck_s & ~sck_q;
   assign cs_fall  = cs_q & ~cs_s;

   // decoder state
   mw_state_e         st_q;
   mw_prog_e          pend_q;
   logic [CNT_W-1:0]  bcnt_q;
   logic [HW-2:0]     hdr_q;
   logic [WORD_W-1:0] dat_q, rd_sr_q;
   logic [NAW-1:0]    addr_q;
   logic              wen_q, do_q, stat_q, clr_arm_q;
   logic              busy, prog_go, rd_act;

   // field extraction from the header including the bit now arriving
   logic [HW-1:0]     hdr_nx;
   logic [1:0]        op_f, ext_f;
   logic [NAW-1:0]    adr_f, addr_inc, fetch_a;
   logic [CNT_W-1:0]  hdr_last, dw_last;
   logic [WORD_W-1:0] rd_word, fetch_w, wr_data, wr_mask;
   logic [AW-1:0]     rd_idx, wr_idx;
   logic              bulk;

   assign hdr_nx   = {hdr_q, sdi_s};
   assign op_f     = org_i ? hdr_nx[AW+1:AW]   : hdr_nx[NAW+1:NAW];
   assign ext_f    = org_i ? hdr_nx[AW-1:AW-2] : hdr_nx[NAW-1:NAW-2];
   assign adr_f    = org_i ? {1'b0, hdr_nx[AW-1:0]} : hdr_nx[NAW-1:0];
   assign hdr_last = org_i ? CNT_W'(1 + AW) : CNT_W'(1 + NAW);
   assign dw_last  = org_i ? CNT_W'(WORD_W - 1) : CNT_W'(NW - 1);
   assign addr_inc = org_i ? {1'b0, addr_q[AW-1:0] + AW'(1)} : addr_q + NAW'(1);

   assign fetch_a  = (st_q == ST_READ) ? addr_inc : adr_f;
   assign rd_idx   = org_i ? fetch_a[AW-1:0] : fetch_a[NAW-1:1];
   assign fetch_w  = org_i     ? rd_word :
                     fetch_a[0] ? {rd_word[WORD_W-1:NW], {NW{1'b0}}} :
                                  {rd_word[NW-1:0],      {NW{1'b0}}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         pend_q  <= PG_NONE;
         bcnt_q  <= '0;
         hdr_q   <= '0;
         dat_q   <= '0;
         rd_sr_q <= '0;
         addr_q  <= '0;
         wen_q   <= 1'b0;
         do_q    <= 1'b0;
      end else if (!cs_s) begin
         st_q   <= ST_IDLE;
         pend_q <= PG_NONE;
         bcnt_q <= '0;
         hdr_q  <= '0;
         do_q   <= 1'b0;
      end else if (sck_rise) begin
         unique case (st_q)
            ST_IDLE: if (sdi_s && !busy) begin
               st_q   <= ST_HDR;
               bcnt_q <= '0;
               hdr_q  <= '0;
            end
            ST_HDR: begin
               hdr_q  <= hdr_nx[HW-2:0];
               bcnt_q <= bcnt_q + CNT_W'(1);
               if (bcnt_q == hdr_last) begin
                  addr_q <= adr_f;
                  bcnt_q <= '0;
                  unique case (op_f)
                     OPC_READ: begin
                        st_q    <= ST_READ;
                        do_q    <= 1'b0;
                        rd_sr_q <= fetch_w;
                     end
                     OPC_WRITE: begin
                        st_q   <= ST_DATA;
                        pend_q <= PG_WORD;
                     end
                     OPC_ERASE: begin
                        st_q   <= ST_DONE;
                        pend_q <= PG_CLEAR;
                     end
                     default: begin
                        st_q <= ST_DONE;
                        unique case (ext_f)
                           EXT_WEN:  wen_q  <= 1'b1;
                           EXT_WDIS: wen_q  <= 1'b0;
                           EXT_WIPE: pend_q <= PG_WIPE;
                           default: begin
                              pend_q <= PG_FILL;
                              st_q   <= ST_DATA;
                           end
                        endcase
                     end
                  endcase
               end
            end
            ST_DATA: begin
               dat_q  <= {dat_q[WORD_W-2:0], sdi_s};
               bcnt_q <= bcnt_q + CNT_W'(1);
               if (bcnt_q == dw_last) st_q <= ST_DONE;
            end
            ST_READ: begin
               do_q    <= rd_sr_q[WORD_W-1];
               rd_sr_q <= {rd_sr_q[WORD_W-2:0], 1'b0};
               if (bcnt_q == dw_last) begin
                  bcnt_q  <= '0;
                  addr_q  <= addr_inc;
                  rd_sr_q <= fetch_w;
               end else begin
                  bcnt_q <= bcnt_q + CNT_W'(1);
               end
            end
            default: ;
         endcase
      end
   end

   // programming launch and status flag
   assign prog_go = cs_fall && (st_q == ST_DONE) && (pend_q != PG_NONE) && wen_q && !busy;
   assign bulk    = (pend_q == PG_FILL) || (pend_q == PG_WIPE);
   assign wr_idx  = org_i ? addr_q[AW-1:0] : addr_q[NAW-1:1];
   assign wr_data = (pend_q == PG_CLEAR || pend_q == PG_WIPE) ? '1 :
                    org_i ? dat_q : {dat_q[NW-1:0], dat_q[NW-1:0]};
   assign wr_mask = (bulk || org_i) ? '1 :
                    addr_q[0] ? {{NW{1'b1}}, {NW{1'b0}}} : {{NW{1'b0}}, {NW{1'b1}}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q    <= 1'b0;
         clr_arm_q <= 1'b0;
      end else begin
         if (prog_go)                 stat_q <= 1'b1;
         else if (cs_fall && clr_arm_q) stat_q <= 1'b0;
         if (cs_fall)                 clr_arm_q <= 1'b0;
         else if (cs_s && sck_rise && sdi_s && st_q == ST_IDLE && !busy)
                                      clr_arm_q <= 1'b1;
      end
   end

   mw_prog_timer #(.SHORT_CYC(PROG_CYC), .LONG_CYC(BULK_CYC)) u_timer (
      .clk(clk), .rst_n(rst_n), .start_i(prog_go), .long_i(bulk), .busy_o(busy));

   mw_array #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_array (
      .clk(clk), .rst_n(rst_n), .wr_en_i(prog_go), .wr_all_i(bulk),
      .wr_idx_i(wr_idx), .wr_data_i(wr_data), .wr_mask_i(wr_mask),
      .rd_idx_i(rd_idx), .rd_data_o(rd_word));

   assign rd_act   = (st_q == ST_READ);
   assign sdo_oe_o = cs_s && (rd_act || (st_q == ST_IDLE && stat_q));
   assign sdo_o    = rd_act ? do_q : ~busy;
endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk #(
   parameter int LONG_CYC = 300
) (
   input logic clk,
   input logic rst_n,
   input logic cs_s,
   input logic busy,
   input logic wen,
   input logic rd_act,
   input logic sdo_o,
   input logic sdo_oe_o
);
   localparam int CW = $clog2(LONG_CYC + 2);
   logic [CW-1:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        run_q <= '0;
      else if (!busy)                    run_q <= '0;
      else if (run_q != CW'(LONG_CYC + 1)) run_q <= run_q + CW'(1);
   end

   AST_OE_OFF_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_s |-> !sdo_oe_o); // R8
   AST_BUSY_READS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (sdo_oe_o && busy) |-> !sdo_o); // R9
   AST_PROG_NEEDS_WEN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(wen)); // R4
   AST_WEN_HOLD_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_s && $past(!cs_s)) |-> $stable(wen)); // R4
   AST_DUMMY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_act) |-> (sdo_oe_o && !sdo_o)); // R5
   AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (run_q < CW'(LONG_CYC))); // R10
endmodule

bind mw_eeprom mw_eeprom_chk #(.LONG_CYC(BULK_CYC)) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .busy(busy), .wen(wen_q),
   .rd_act(rd_act), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o));

// File: tb/mw_eeprom_tb_top.sv
module mw_eeprom_tb_top;
   localparam int PROG = 1000;
   localparam int BULK = 2500;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs = 1'b0, sck = 1'b0, sdi = 1'b0, org = 1'b1;
   logic sdo, oe;

   int   n_chk = 0;
   int   n_fail = 0;
   bit   done = 1'b0;
   logic  exp_q[$];
   string tag_q[$];
   event  smp_ev;

   always #2 clk = ~clk;   // 250 MHz

   mw_eeprom #(.PROG_CYC(PROG), .BULK_CYC(BULK)) dut_i (
      .clk(clk), .rst_n(rst_n), .cs_i(cs), .sck_i(sck), .sdi_i(sdi),
      .org_i(org), .sdo_o(sdo), .sdo_oe_o(oe));

   task automatic wait_c(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   // scoreboard monitor: pops one expected bit per sample event
   initial begin
      forever begin
         @(smp_ev);
         n_chk++;
         if (exp_q.size() == 0) begin
            n_fail++;
            $display("FAIL unexpected sample: got oe=%b do=%b expected nothing", oe, sdo);
         end else begin
            automatic logic  e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            if ({oe, sdo} !== {1'b1, e}) begin
               n_fail++;
               $display("FAIL %s: got oe=%b do=%b expected oe=1 do=%b", t, oe, sdo, e);
            end
         end
      end
   end

   task automatic tick(input logic b, input logic smp);
      sdi = b;
      wait_c(8); sck = 1'b1;
      wait_c(8); sck = 1'b0;
      wait_c(4);
      if (smp) ->smp_ev;
      wait_c(4);
   endtask

   task automatic sel();
      wait_c(8); cs = 1'b1; wait_c(8);
   endtask

   task automatic desel();
      sck = 1'b0; sdi = 1'b0; cs = 1'b0; wait_c(16);
   endtask

   task automatic hdr(input logic [1:0] op, input int a, input logic smp_last);
      automatic int aw = org ? 6 : 7;
      tick(1'b1, 1'b0);
      tick(op[1], 1'b0);
      tick(op[0], 1'b0);
      for (int i = aw - 1; i >= 0; i--) tick(a[i], (i == 0) && smp_last);
   endtask

   task automatic cmd(input logic [1:0] op, input int a, input logic [15:0] d, input int nbits);
      automatic int dw = org ? 16 : 8;
      sel();
      hdr(op, a, 1'b0);
      for (int i = dw - 1; i >= dw - nbits; i--) tick(d[i], 1'b0);
      desel();
   endtask

   task automatic ext(input logic [1:0] code, input logic [15:0] d, input int nbits);
      automatic int aw = org ? 6 : 7;
      cmd(2'b00, int'(code) << (aw - 2), d, nbits);
   endtask

   task automatic rd(input int a, input int lead, input int n, input logic [15:0] w0,
                     input logic [15:0] w1, input logic [15:0] w2, input string tag);
      automatic int dw = org ? 16 : 8;
      exp_q.push_back(1'b0); tag_q.push_back(tag);
      for (int k = 0; k < n; k++) begin
         automatic logic [15:0] w = (k == 0) ? w0 : (k == 1) ? w1 : w2;
         for (int b = dw - 1; b >= 0; b--) begin
            exp_q.push_back(w[b]); tag_q.push_back(tag);
         end
      end
      sel();
      for (int i = 0; i < lead; i++) tick(1'b0, 1'b0);
      hdr(2'b10, a, 1'b1);
      for (int i = 0; i < n * dw; i++) tick(1'b0, 1'b1);
      desel();
   endtask

   task automatic status(input string tag, input logic e_oe, input logic e_do);
      sel();
      wait_c(4);
      chk(tag, {15'd0, oe}, {15'd0, e_oe});
      if (e_oe) chk(tag, {15'd0, sdo}, {15'd0, e_do});
      desel();
   endtask

   task automatic clear_stat();
      sel(); tick(1'b1, 1'b0); desel();
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1'b1;
         $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_up();
   end

   initial begin
      wait_c(10); rst_n = 1'b1; wait_c(5);
      chk("R8 reset oe", {15'd0, oe}, 16'd0);

      // R1 leading zero clocks, R13 erased content
      rd(3, 5, 1, 16'hFFFF, 0, 0, "R1/R13 read after idle clocks");

      // R4 write while disabled
      cmd(2'b01, 3, 16'h1234, 16);
      status("R4 no interval when disabled", 1'b0, 1'b0);
      rd(3, 0, 1, 16'hFFFF, 0, 0, "R4 word unchanged");

      // R2 enable then write; R9 busy/ready/clear
      ext(2'b11, 0, 0);
      cmd(2'b01, 3, 16'hA55A, 16);
      status("R9 busy reads 0", 1'b1, 1'b0);
      wait_c(PROG + 100);
      status("R9 ready reads 1", 1'b1, 1'b1);
      clear_stat();
      status("R9 status cleared", 1'b0, 1'b0);

      cmd(2'b01, 4, 16'h0F0F, 16);
      wait_c(PROG + 100); clear_stat();
      rd(3, 0, 3, 16'hA55A, 16'h0F0F, 16'hFFFF, "R5 streaming read");

      // R12 wrap
      cmd(2'b01, 0, 16'h2468, 16); wait_c(PROG + 100); clear_stat();
      cmd(2'b01, 63, 16'h1357, 16); wait_c(PROG + 100); clear_stat();
      rd(63, 0, 2, 16'h1357, 16'h2468, 0, "R12 wrap to word 0");

      // R6 erase one word
      cmd(2'b11, 3, 0, 0); wait_c(PROG + 100); clear_stat();
      rd(3, 0, 1, 16'hFFFF, 0, 0, "R6 erase word");

      // R7 truncated write
      cmd(2'b01, 4, 16'h0000, 10);
      status("R7 truncated no interval", 1'b0, 1'b0);
      rd(4, 0, 1, 16'h0F0F, 0, 0, "R7 word kept");

      // R11 instruction during busy is ignored
      cmd(2'b01, 5, 16'h1111, 16);
      cmd(2'b01, 6, 16'h2222, 16);
      wait_c(PROG + 100); clear_stat();
      rd(5, 0, 2, 16'h1111, 16'hFFFF, 0, "R11 busy-time write dropped");

      // R10 long interval for write-all
      ext(2'b01, 16'h5A5A, 16);
      status("R10 bulk busy early", 1'b1, 1'b0);
      wait_c(PROG + 100);
      status("R10 bulk still busy past short time", 1'b1, 1'b0);
      wait_c(BULK - PROG);
      status("R10 bulk ready", 1'b1, 1'b1);
      clear_stat();
      rd(10, 0, 1, 16'h5A5A, 0, 0, "R6 write-all");
      rd(62, 0, 3, 16'h5A5A, 16'h5A5A, 16'h5A5A, "R6 write-all across wrap");

      // R3 byte mode and mapping
      org = 1'b0; wait_c(8);
      cmd(2'b01, 9, 16'h00C3, 8); wait_c(PROG + 100); clear_stat();
      rd(8, 0, 2, 16'h005A, 16'h00C3, 0, "R3 byte read");
      rd(127, 0, 2, 16'h005A, 16'h005A, 0, "R12 byte wrap");
      org = 1'b1; wait_c(8);
      rd(4, 0, 1, 16'hC35A, 0, 0, "R3 odd byte is upper half");

      // R6 erase-all
      ext(2'b10, 0, 0);
      status("R2 erase-all started", 1'b1, 1'b0);
      wait_c(BULK + 100); clear_stat();
      rd(0, 0, 2, 16'hFFFF, 16'hFFFF, 0, "R6 erase-all");

      // R4 disable persists
      ext(2'b00, 0, 0);
      cmd(2'b01, 2, 16'h0000, 16);
      status("R4 disabled again", 1'b0, 1'b0);
      rd(2, 0, 1, 16'hFFFF, 0, 0, "R4 write blocked after disable");

      // R8 select low stops a read
      sel(); hdr(2'b10, 1, 1'b0); tick(1'b0, 1'b0); tick(1'b0, 1'b0);
      desel();
      chk("R8 oe after abort", {15'd0, oe}, 16'd0);
      rd(1, 0, 1, 16'hFFFF, 0, 0, "R8 decoder restarted");

      chk("scoreboard drained", 16'(exp_q.size()), 16'd0);
      finish_up();
   end
endmodule